// File: doc/BRIEF.md
# EDO DRAM Access Controller

This block sits between a synchronous on-chip requester and an asynchronous 16-bit extended-data-out DRAM. The requester presents a word address, a read/write flag, two byte enables and write data. The controller acknowledges the request in the cycle it accepts it. It splits the address into a row half and a column half and places them on one multiplexed address bus. It sequences the active-low row strobe, the two byte-lane column strobes, the write enable and the output enable. Every minimum interval is a whole number of clock cycles, computed from nanosecond parameters and the clock-period parameter.

After an access, the row stays open. A later request to the same row is served as a page access: a new column strobe with the row strobe held low. A request to another row, a refresh arbitration request, or the maximum row-strobe low time closes the row, and precharge follows. Writes are early writes: write enable is low before the column strobe falls, and output enable stays high, so the DRAM never drives its data pins. Read data is registered at the end of the column-strobe low window and flagged with a one-cycle response pulse. Refresh and power-up are left to a separate scheduler. That scheduler asks for the pins with `arbReq` and owns them while `arbGnt` is high.

Top module: `edo_dram_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, rasN, casLoN, casHiN, weN and oeN are 1, and reqAck, rspValid, arbGnt and dqOe are 0.
- R2: rasN never falls before it has been high for at least RP cycles, the precharge time rounded up to clocks (2 at defaults).
- R3: For the first RAH cycles of each row-strobe low period (1 at defaults), dramAddr carries the row, which is reqAddr bits [19:COL_W]. When a column strobe falls it carries the column, which is reqAddr bits [COL_W-1:0] zero-extended (COL_W = 10 at defaults). No column strobe falls earlier than RCD cycles (1) after rasN falls, and none is low while rasN is high.
- R4: A column strobe stays low for at least CASL cycles (1), the larger of the pulse-width and access-time limits. Between strobes in one row period, both strobes stay high for at least CP cycles (1), and successive falls are at least HPC cycles (2) apart.
- R5: reqByteEn bit 0 selects casLoN (data bits 7:0) and bit 1 selects casHiN (data bits 15:8). Only enabled strobes fall, and they fall together.
- R6: For a write, weN is low in the cycle before the column strobe falls and while it is low. oeN is high whenever weN is low. dqOe is 1 and dqOut equals the write data while weN is low.
- R7: A read produces exactly one rspValid pulse. On the enabled lanes, rspData equals the last data written to that address. The pulse comes 1+RAH+COL+CASL cycles after the acknowledge cycle for a row that had to be opened (4 at defaults), and 2+CASL cycles (3) for a page hit.
- R8: A request to the open row is acknowledged while rasN stays low, and a run of same-row requests uses a single rasN fall.
- R9: A request to a different row raises rasN, precharges and opens the new row, so rasN falls once more.
- R10: rasN is never low for more than RASMAX cycles (500 at defaults); an idle open row is closed before that limit.
- R11: arbGnt rises only after rasN has been high for RP cycles. While arbGnt is 1, rasN and both column strobes are high and reqAck is 0. arbGnt is 0 in the cycle after arbReq is seen low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present; held until reqAck |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 20 | Word address, row in the upper bits |
| reqByteEn | input | 2 | Byte lane enables |
| reqWData | input | 16 | Write data |
| reqAck | output | 1 | Request accepted this cycle |
| rspValid | output | 1 | One-cycle read data pulse |
| rspData | output | 16 | Captured read data |
| arbReq | input | 1 | Refresh scheduler asks for the DRAM pins |
| arbGnt | output | 1 | Pins released to the scheduler |
| dramAddr | output | 10 | Multiplexed row/column address |
| rasN | output | 1 | Row strobe, active low |
| casLoN | output | 1 | Lower byte column strobe, active low |
| casHiN | output | 1 | Upper byte column strobe, active low |
| weN | output | 1 | Write enable, active low |
| oeN | output | 1 | Output enable, active low |
| dqOut | output | 16 | Write data toward the DRAM |
| dqIn | input | 16 | Read data from the DRAM |
| dqOe | output | 1 | Drive enable for dqOut |

## Verification
A wrong state or counter shows at the pins in the same cycle. A precharge or strobe count that is off by one shortens a rasN-high or column-strobe window at the next edge of that strobe. A stale row register shows as a wrong address on the first row-strobe low cycle, or as an acknowledge with rasN low for a different row. A capture point that is off by one cycle picks up the idle-bus value instead of the cell data, and it moves the response pulse, so the data or latency comparison fails on the first read.

// File: rtl/edo_ctrl_pkg.sv
package edo_ctrl_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_GRANT, S_ROW, S_COL, S_CASL, S_CASH, S_OPEN
  } ctlState_t;

  typedef struct packed {
    logic load;     // latch a new request
    logic selCol;   // column half on the address bus
    logic capture;  // register the read data
  } dpStrobe_t;

  function automatic int nsToCyc(input int ns, input int clkNs);
    int c;
    c = (ns + clkNs - 1) / clkNs;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/edo_ctrl_dp.sv
module edo_ctrl_dp
  import edo_ctrl_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int COL_W  = 10,
  parameter int PIN_W  = 10,
  parameter int DATA_W = 16,
  parameter int BE_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [BE_W-1:0]   reqByteEn,
  input  logic [DATA_W-1:0] reqWData,
  output logic              rowHit,
  output logic              curWrite,
  output logic [BE_W-1:0]   curBe,
  output logic [PIN_W-1:0]  dramAddr,
  output logic [DATA_W-1:0] dqOut,
  input  logic [DATA_W-1:0] dqIn,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData
);

  localparam int ROW_W = ADDR_W - COL_W;

  logic [ADDR_W-1:0] addrReg;
  logic [ROW_W-1:0]  rowPart;
  logic [COL_W-1:0]  colPart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg  <= '0;
      curWrite <= 1'b0;
      curBe    <= '0;
      dqOut    <= '0;
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      if (strobe.load) begin
        addrReg  <= reqAddr;
        curWrite <= reqWrite;
        curBe    <= reqByteEn;
        dqOut    <= reqWData;
      end
      rspValid <= strobe.capture;
      if (strobe.capture) rspData <= dqIn;
    end
  end

  assign rowPart  = addrReg[ADDR_W-1:COL_W];
  assign colPart  = addrReg[COL_W-1:0];
  assign rowHit   = (reqAddr[ADDR_W-1:COL_W] == rowPart);
  assign dramAddr = strobe.selCol ? PIN_W'(colPart) : PIN_W'(rowPart);

  p_rsp_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

endmodule

// File: rtl/edo_ctrl_fsm.sv
module edo_ctrl_fsm
  import edo_ctrl_pkg::*;
#(
  parameter int RP_C     = 2,
  parameter int RAH_C    = 1,
  parameter int COL_C    = 1,
  parameter int CASL_C   = 1,
  parameter int CPH_C    = 1,
  parameter int RASMAX_C = 500,
  parameter int CNT_W    = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output logic       reqAck,
  input  logic       arbReq,
  output logic       arbGnt,
  input  logic       rowHit,
  input  logic       curWrite,
  input  logic [1:0] curBe,
  output dpStrobe_t  strobe,
  output logic       rasN,
  output logic       casLoN,
  output logic       casHiN,
  output logic       weN,
  output logic       oeN,
  output logic       dqOe
);

  localparam int HIT_SPAN = 3 + CASL_C + CPH_C;

  ctlState_t        state, nextState;
  logic [CNT_W-1:0] cnt, nextCnt, preCnt, rasCnt;
  logic             budgetOk, wrPhase, inCas;

  assign budgetOk = (rasCnt + CNT_W'(HIT_SPAN)) <= CNT_W'(RASMAX_C);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      cnt    <= '0;
      preCnt <= CNT_W'(RP_C - 1);
      rasCnt <= '0;
    end else begin
      state  <= nextState;
      cnt    <= nextCnt;
      if (state == S_IDLE) preCnt <= (preCnt != '0) ? preCnt - 1'b1 : preCnt;
      else                 preCnt <= CNT_W'(RP_C - 1);
      rasCnt <= rasN ? '0 : rasCnt + 1'b1;
    end
  end

  always_comb begin
    nextState = state;
    nextCnt   = cnt;
    reqAck    = 1'b0;
    strobe    = '0;
    case (state)
      S_IDLE: if (preCnt == '0) begin
        if (arbReq) nextState = S_GRANT;
        else if (reqValid) begin
          reqAck      = 1'b1;
          strobe.load = 1'b1;
          nextState   = S_ROW;
          nextCnt     = CNT_W'(RAH_C - 1);
        end
      end
      S_GRANT: if (!arbReq) nextState = S_IDLE;
      S_ROW: begin
        if (cnt == '0) begin
          nextState = S_COL;
          nextCnt   = CNT_W'(COL_C - 1);
        end else nextCnt = cnt - 1'b1;
      end
      S_COL: begin
        strobe.selCol = 1'b1;
        if (cnt == '0) begin
          nextState = S_CASL;
          nextCnt   = CNT_W'(CASL_C - 1);
        end else nextCnt = cnt - 1'b1;
      end
      S_CASL: begin
        strobe.selCol = 1'b1;
        if (cnt == '0) begin
          strobe.capture = !curWrite;
          nextState      = S_CASH;
          nextCnt        = CNT_W'(CPH_C - 1);
        end else nextCnt = cnt - 1'b1;
      end
      S_CASH: begin
        strobe.selCol = 1'b1;
        if (cnt == '0) nextState = S_OPEN;
        else           nextCnt   = cnt - 1'b1;
      end
      S_OPEN: begin
        strobe.selCol = 1'b1;
        if (arbReq || !budgetOk || (reqValid && !rowHit)) nextState = S_IDLE;
        else if (reqValid) begin
          reqAck      = 1'b1;
          strobe.load = 1'b1;
          nextState   = S_COL;
          nextCnt     = '0;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign rasN    = (state == S_IDLE) || (state == S_GRANT);
  assign arbGnt  = (state == S_GRANT);
  assign inCas   = (state == S_CASL);
  assign casLoN  = !(inCas && curBe[0]);
  assign casHiN  = !(inCas && curBe[1]);
  assign wrPhase = (state == S_COL) || (state == S_CASL);
  assign weN     = !(wrPhase && curWrite);
  assign oeN     = !(wrPhase && !curWrite);
  assign dqOe    = wrPhase && curWrite;

  // checker-side run counter of row-strobe high cycles
  logic [CNT_W-1:0] highRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     highRun <= '0;
    else if (rasN) highRun <= highRun + 1'b1;
    else           highRun <= '0;
  end

  p_precharge_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> (highRun >= CNT_W'(RP_C)));

  p_cas_in_ras_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!casLoN || !casHiN) |-> !rasN);

  p_early_we_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((!casLoN || !casHiN) && !weN) |-> $past(!weN));

  p_we_oe_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    !weN |-> oeN);

  p_ras_limit_r10: assert property (@(posedge clk) disable iff (!rstN)
    !rasN |-> (rasCnt < CNT_W'(RASMAX_C)));

  p_gnt_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    arbGnt |-> (rasN && casLoN && casHiN && !reqAck));

  p_gnt_after_pre_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(arbGnt) |-> (highRun >= CNT_W'(RP_C)));

endmodule

// File: rtl/edo_dram_ctrl.sv
module edo_dram_ctrl
  import edo_ctrl_pkg::*;
#(
  parameter int CLK_NS      = 20,
  parameter int ADDR_W      = 20,
  parameter int ROW_W       = 10,
  parameter int T_RP_NS     = 40,
  parameter int T_RAH_NS    = 10,
  parameter int T_RCD_NS    = 20,
  parameter int T_CAS_NS    = 13,
  parameter int T_CAC_NS    = 15,
  parameter int T_CP_NS     = 7,
  parameter int T_HPC_NS    = 25,
  parameter int T_RASMAX_NS = 10000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqByteEn,
  input  logic [15:0]       reqWData,
  output logic              reqAck,
  output logic              rspValid,
  output logic [15:0]       rspData,
  input  logic              arbReq,
  output logic              arbGnt,
  output logic [((ROW_W > ADDR_W-ROW_W) ? ROW_W : ADDR_W-ROW_W)-1:0] dramAddr,
  output logic              rasN,
  output logic              casLoN,
  output logic              casHiN,
  output logic              weN,
  output logic              oeN,
  output logic [15:0]       dqOut,
  input  logic [15:0]       dqIn,
  output logic              dqOe
);

  localparam int COL_W    = ADDR_W - ROW_W;
  localparam int PIN_W    = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int RP_C     = nsToCyc(T_RP_NS, CLK_NS);
  localparam int RAH_C    = nsToCyc(T_RAH_NS, CLK_NS);
  localparam int RCD_C    = nsToCyc(T_RCD_NS, CLK_NS);
  localparam int COL_C    = (RCD_C > RAH_C) ? RCD_C - RAH_C : 1;
  localparam int CASW_C   = nsToCyc(T_CAS_NS, CLK_NS);
  localparam int CAC_C    = nsToCyc(T_CAC_NS, CLK_NS);
  localparam int CASL_C   = (CASW_C > CAC_C) ? CASW_C : CAC_C;
  localparam int CP_C     = nsToCyc(T_CP_NS, CLK_NS);
  localparam int HPC_C    = nsToCyc(T_HPC_NS, CLK_NS);
  localparam int CPH_C    = (CP_C > HPC_C - CASL_C) ? CP_C : HPC_C - CASL_C;
  localparam int RASMAX_C = T_RASMAX_NS / CLK_NS;
  localparam int CNT_W    = $clog2(RASMAX_C + CASL_C + CPH_C + RP_C + 8);

  dpStrobe_t  strobe;
  logic       rowHit, curWrite;
  logic [1:0] curBe;

  edo_ctrl_fsm #(
    .RP_C(RP_C), .RAH_C(RAH_C), .COL_C(COL_C), .CASL_C(CASL_C),
    .CPH_C(CPH_C), .RASMAX_C(RASMAX_C), .CNT_W(CNT_W)
  ) i_fsm (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAck(reqAck),
    .arbReq(arbReq), .arbGnt(arbGnt), .rowHit(rowHit),
    .curWrite(curWrite), .curBe(curBe), .strobe(strobe),
    .rasN(rasN), .casLoN(casLoN), .casHiN(casHiN),
    .weN(weN), .oeN(oeN), .dqOe(dqOe)
  );

  edo_ctrl_dp #(
    .ADDR_W(ADDR_W), .COL_W(COL_W), .PIN_W(PIN_W), .DATA_W(16), .BE_W(2)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqByteEn(reqByteEn), .reqWData(reqWData),
    .rowHit(rowHit), .curWrite(curWrite), .curBe(curBe),
    .dramAddr(dramAddr), .dqOut(dqOut), .dqIn(dqIn),
    .rspValid(rspValid), .rspData(rspData)
  );

endmodule

// File: tb/test_edo_dram_ctrl.sv
module test_edo_dram_ctrl;

  localparam int COL_W = 10;
  // expected cycle counts at 20 ns clock, rounded up from the ns limits
  localparam int RP_C = 2, RAH_C = 1, RCD_C = 1, COL_C = 1, CASL_C = 1;
  localparam int CP_C = 1, HPC_C = 2, RASMAX_C = 500;

  logic clk = 0, rstN = 0;
  logic reqValid = 0, reqWrite = 0, arbReq = 0;
  logic [19:0] reqAddr = '0;
  logic [1:0]  reqByteEn = '0;
  logic [15:0] reqWData = '0, dqIn = 16'hEEEE;
  logic reqAck, rspValid, arbGnt, rasN, casLoN, casHiN, weN, oeN, dqOe;
  logic [15:0] rspData, dqOut;
  logic [9:0]  dramAddr;

  edo_dram_ctrl i_edo_dram_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqByteEn(reqByteEn), .reqWData(reqWData),
    .reqAck(reqAck), .rspValid(rspValid), .rspData(rspData),
    .arbReq(arbReq), .arbGnt(arbGnt), .dramAddr(dramAddr),
    .rasN(rasN), .casLoN(casLoN), .casHiN(casHiN), .weN(weN), .oeN(oeN),
    .dqOut(dqOut), .dqIn(dqIn), .dqOe(dqOe)
  );

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;
  logic [15:0] sb  [int];
  logic [15:0] mem [int];

  int curAddr = 0, lastAddr = -1, ackCyc = 0;
  bit curWr = 0;
  logic [1:0] curBe = 0;
  logic [15:0] curData = 0;
  int rasFalls = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [15:0] rdMap(input int a, input bit fromSb);
    if (fromSb) return sb.exists(a) ? sb[a] : 16'h0;
    return mem.exists(a) ? mem[a] : 16'h0;
  endfunction

  task automatic summary();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      summary();
    end
  end

  // pin-level reference of the DRAM timing rules plus a behavioural memory
  int rasHigh = 0, rasLow = 0, casHigh = 0, casLow = 0, lastFall = -1;
  bit prevRas = 1, prevCas = 0, prevWe = 1, prevRsp = 0, prevGnt = 0;
  int rowL = 0, colL = 0;
  always @(negedge clk) begin
    bit casAny;
    casAny = !casLoN || !casHiN;
    if (rstN && !finished) begin
      if (!rasN && prevRas) begin
        chk(rasHigh >= RP_C, "R2 precharge", rasHigh, RP_C);
        chk(dramAddr == 10'(curAddr >> COL_W), "R3 row addr", dramAddr, curAddr >> COL_W);
        rasFalls++; rowL = int'(dramAddr); rasLow = 0; lastFall = -1;
      end
      if (!rasN && rasLow < RAH_C)
        chk(int'(dramAddr) == rowL, "R3 row hold", dramAddr, rowL);
      if (casAny) chk(!rasN, "R3 cas inside ras", rasN, 0);
      if (casAny && !prevCas) begin
        chk(rasLow >= RCD_C, "R3 ras-to-cas", rasLow, RCD_C);
        chk(dramAddr == 10'(curAddr), "R3 col addr", dramAddr, curAddr & 1023);
        chk({!casHiN, !casLoN} == curBe, "R5 lanes", {!casHiN, !casLoN}, curBe);
        if (lastFall >= 0) begin
          chk(casHigh >= CP_C, "R4 cas precharge", casHigh, CP_C);
          chk(cyc - lastFall >= HPC_C, "R4 page cycle", cyc - lastFall, HPC_C);
        end
        lastFall = cyc;
        colL = int'(dramAddr);
        if (curWr) begin
          chk(!weN && !prevWe, "R6 early write", {prevWe, weN}, 0);
          chk(dqOut == curData, "R6 write data", dqOut, curData);
          begin
            int a; logic [15:0] w;
            a = (rowL << COL_W) | colL;
            w = rdMap(a, 0);
            if (!casLoN) w[7:0]  = dqOut[7:0];
            if (!casHiN) w[15:8] = dqOut[15:8];
            mem[a] = w;
          end
        end
      end
      if (!casAny && prevCas) chk(casLow >= CASL_C, "R4 cas width", casLow, CASL_C);
      if (!weN) chk(oeN && dqOe, "R6 oe off, dq driven", {oeN, dqOe}, 3);
      if (!rasN) chk(rasLow < RASMAX_C, "R10 ras low limit", rasLow + 1, RASMAX_C);
      if (arbGnt) chk(rasN && !casAny, "R11 pins idle in grant", {rasN, casAny}, 2);
      if (arbGnt && !prevGnt) chk(rasHigh >= RP_C, "R11 grant after precharge", rasHigh, RP_C);
      if (rspValid) chk(!prevRsp, "R7 single pulse", prevRsp, 0);
      // read data drive: valid only while a strobe and oe are low
      if (casAny && !oeN) begin
        logic [15:0] d;
        d = rdMap((rowL << COL_W) | int'(dramAddr), 0);
        dqIn = {!casHiN ? d[15:8] : 8'hEE, !casLoN ? d[7:0] : 8'hEE};
      end else dqIn = 16'hEEEE;
      if (rasN) begin rasHigh++; rasLow = 0; end else begin rasLow++; rasHigh = 0; end
      if (casAny) begin casLow++; casHigh = 0; end else begin casHigh++; casLow = 0; end
      prevRas = rasN; prevCas = casAny; prevWe = weN; prevRsp = rspValid; prevGnt = arbGnt;
    end
  end

  task automatic access(input bit wr, input int addr, input logic [1:0] be, input logic [15:0] data);
    bit wasOpen;
    int lat, expLat;
    logic [15:0] mask, expD;
    @(negedge clk);
    reqValid = 1; reqWrite = wr; reqAddr = 20'(addr); reqByteEn = be; reqWData = data;
    forever begin
      #1;
      if (reqAck) break;
      @(negedge clk);
    end
    wasOpen = !rasN;
    if (wasOpen) chk((addr >> COL_W) == (lastAddr >> COL_W), "R8 hit only on open row", addr >> COL_W, lastAddr >> COL_W);
    ackCyc = cyc; curAddr = addr; curWr = wr; curBe = be; curData = data; lastAddr = addr;
    if (wr) begin
      logic [15:0] w;
      w = rdMap(addr, 1);
      if (be[0]) w[7:0]  = data[7:0];
      if (be[1]) w[15:8] = data[15:8];
      sb[addr] = w;
    end
    @(posedge clk); #1;
    reqValid = 0;
    if (!wr) begin
      do @(negedge clk); while (!rspValid);
      lat = cyc - ackCyc;
      expLat = 1 + (wasOpen ? 1 : RAH_C + COL_C) + CASL_C;
      chk(lat == expLat, "R7 read latency", lat, expLat);
      mask = {{8{be[1]}}, {8{be[0]}}};
      expD = rdMap(addr, 1) & mask;
      chk((rspData & mask) == expD, "R7 read data", rspData & mask, expD);
    end
  endtask

  initial begin
    int f0;
    repeat (3) @(negedge clk);
    chk(rasN && casLoN && casHiN && weN && oeN, "R1 strobes idle in reset",
        {rasN, casLoN, casHiN, weN, oeN}, 5'h1f);
    chk(!reqAck && !rspValid && !arbGnt && !dqOe, "R1 flags low in reset",
        {reqAck, rspValid, arbGnt, dqOe}, 0);
    rstN = 1;
    @(negedge clk);
    chk(rasN && casLoN && casHiN && weN && oeN && !rspValid && !arbGnt, "R1 after reset",
        {rasN, casLoN, casHiN, weN, oeN}, 5'h1f);

    // single accesses, byte lanes (R5, R6, R7)
    access(1, 20'h12345, 2'b11, 16'hA1B2);
    access(1, 20'h12346, 2'b01, 16'hFF3C);
    access(1, 20'h12346, 2'b10, 16'h5DFF);
    access(1, 20'h80001, 2'b10, 16'h7700);
    access(0, 20'h12345, 2'b11, 0);
    access(0, 20'h12346, 2'b11, 0);
    access(0, 20'h80001, 2'b10, 0);
    access(0, 20'h12345, 2'b01, 0);

    // page burst on one row (R8)
    for (int i = 0; i < 4; i++) access(1, 20'h2A000 + i, 2'b11, 16'(16'h1000 * i + i));
    access(0, 20'h33003, 2'b11, 0);
    f0 = rasFalls;
    for (int i = 0; i < 4; i++) access(0, 20'h2A000 + i, 2'b11, 0);
    chk(rasFalls == f0 + 1, "R8 one ras fall per page burst", rasFalls, f0 + 1);

    // row change (R9)
    access(0, 20'h55001, 2'b11, 0);
    chk(rasFalls == f0 + 2, "R9 new row reopens", rasFalls, f0 + 2);

    // arbitration (R11)
    @(negedge clk); arbReq = 1;
    do @(negedge clk); while (!arbGnt);
    chk(rasN, "R11 row closed for grant", rasN, 1);
    reqValid = 1; reqAddr = 20'h55002; reqWrite = 0; reqByteEn = 2'b11;
    for (int i = 0; i < 5; i++) begin
      #1; chk(!reqAck && arbGnt, "R11 no ack in grant", {reqAck, arbGnt}, 1);
      @(negedge clk);
    end
    reqValid = 0; arbReq = 0;
    @(negedge clk); @(negedge clk);
    chk(!arbGnt, "R11 grant released", arbGnt, 0);
    access(0, 20'h55002, 2'b11, 0);

    // open row timeout (R10)
    access(0, 20'h2A001, 2'b11, 0);
    repeat (RASMAX_C + 50) @(negedge clk);
    chk(rasN, "R10 idle row closed", rasN, 1);

    // mixed pattern
    for (int i = 0; i < 40; i++) begin
      int a;
      a = ((i % 3) << 15) | ((i * 13) % 64);
      access((i % 3) != 2, a, 2'((i % 3) + 1), 16'(i * 16'h0911 + 3));
      access(0, a, 2'b11, 0);
    end

    summary();
  end

endmodule